// File: doc/BRIEF.md
# Page-buffered nonvolatile write sequencer

This block is the control side of a byte-wide nonvolatile memory. A host drives active-low chip-select, write-strobe and read-strobe lines plus a write-permit line. All of them are sampled in one system clock domain. Each completed write strobe drops one byte into a page latch of 2^PAGE_BITS entries. Every byte opens a load window. Once the window has lapsed and the bus has stayed quiet long enough, the block programs the loaded bytes into a behavioural cell array. While that program cycle runs, it pulls a ready/busy line low and answers reads with a polling value.

The controller has four states. ST_IDLE waits for the first byte. ST_LOAD accepts further bytes and restarts its timer on each one. ST_HOLD has a closed window and counts down to the start of programming. ST_PROG writes the array. The transitions are:
- IDLE→LOAD on the first accepted byte.
- LOAD→LOAD on each further byte, which restarts the timer.
- LOAD→HOLD when the load window lapses.
- HOLD→PROG when the start delay expires.
- PROG→IDLE when the program time ends.
- LOAD/HOLD/PROG→IDLE when the permit line goes low. In LOAD or HOLD the page is discarded. In PROG the cycle stops.

All times are parameters in clock cycles.

Top module: `eeprom_page_seq`

## Requirements
- R1: After system reset, rb_low is 0 and the controller sits in ST_IDLE.
- R2: A write is active while ce_n=0, we_n=0 and oe_n=1. The address is taken in the first clock where the write becomes active, so it follows whichever strobe fell last. The data is taken in the first clock where it stops being active, so it follows whichever strobe rose first.
- R3: The low PAGE_BITS address bits select the byte within the page. The upper bits of the first byte fix the page. Later bytes' upper bits are ignored.
- R4: A byte whose write ends within LOAD_WIN clocks of the previous accepted byte joins the page. A byte arriving after the window has lapsed (ST_HOLD) is ignored.
- R5: Programming starts START_DLY clocks after the last accepted byte. rb_low goes to 1 in the clock that ST_PROG is entered and stays 1 for PROG_CYC clocks.
- R6: Only page entries that were loaded change in the array. The other bytes of the page keep their old contents.
- R7: A read (ce_n=0, oe_n=0, we_n=1) during ST_PROG returns the last loaded byte with bit 7 inverted and bits 6..0 unchanged. dout_en is 1 during any read.
- R8: After the program cycle ends, reads return the stored array data.
- R9: While res_n=0, no byte is accepted and no program starts. res_n going low in ST_LOAD or ST_HOLD discards the page. res_n going low in ST_PROG drops rb_low in the next clock.
- R10: A strobe with oe_n=0 is not a write and loads nothing.
- R11: Write strobes during ST_PROG are ignored. They neither change the page latch nor start a further program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read strobe |
| res_n | input | 1 | Write permit; low blocks all programming |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling value |
| dout_en | output | 1 | High while a read is in progress |
| rb_low | output | 1 | 1 = pull ready/busy low; 0 = line released |

## Verification
The main function is tried with several input patterns:
- Single-byte and multi-byte pages, including a byte whose upper address bits differ from the page. This separates correct in-page placement from plain address use.
- Both strobe orders, with the address and data changed while the write is active. This shows which edge captures each of them.
- A late byte after the window has lapsed, a strobe with the read strobe held low, writes with the permit line low, and a page discarded by a permit drop. Each must leave earlier array contents readable and unchanged.
- Polling reads during programming, and strobes arriving while busy. These separate the inverted-bit-7 status from array data and check that busy is ignored.

// File: rtl/eps_pkg.sv
package eps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_HOLD,
        ST_PROG
    } eps_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/eps_bus_decode.sv
module eps_bus_decode #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              byte_done,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        byte_data
);
    logic wr_act;
    logic wr_act_q;
    logic wr_begin;
    logic [ADDR_W-1:0] addr_q;

    // a write is active only with both strobes low and reads off
    assign wr_act   = ~ce_n & ~we_n & oe_n;
    assign wr_begin = wr_act & ~wr_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            wr_act_q <= wr_act;
            if (wr_begin) addr_q <= addr;
        end
    end

    assign byte_done = ~wr_act & wr_act_q;
    assign byte_addr = addr_q;
    assign byte_data = din;
endmodule

// File: rtl/eps_page_latch.sv
module eps_page_latch #(
    parameter int PAGE_BITS = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 we,
    input  logic [PAGE_BITS-1:0] wr_idx,
    input  logic [7:0]           wr_data,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [7:0]           rd_data,
    output logic                 rd_valid
);
    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    logic [7:0]            slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  valid_q <= '0;
        else if (clr) valid_q <= '0;
        else if (we)  valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) slot_q[wr_idx] <= wr_data;
    end

    assign rd_data  = slot_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/eps_cell_array.sv
module eps_cell_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq
    import eps_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PAGE_BITS = 7,
    parameter int LOAD_WIN  = 1500,
    parameter int START_DLY = 5000,
    parameter int PROG_CYC  = 750000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              res_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              rb_low
);
    localparam int PAGE_BYTES = 1 << PAGE_BITS;
    localparam int UPPER_W    = ADDR_W - PAGE_BITS;
    localparam int CNT_W      = $clog2(PROG_CYC + START_DLY + PAGE_BYTES + 1);

    eps_state_t state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [UPPER_W-1:0] page_q;
    logic [BYTE_W-1:0]  last_q;

    logic              byte_done;
    logic [ADDR_W-1:0] byte_addr;
    logic [7:0]        byte_data;
    logic              accept;
    logic              lat_clr;
    logic [7:0]        lat_rd_data;
    logic              lat_rd_valid;
    logic              arr_we;
    logic [7:0]        arr_rdata;

    eps_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .byte_done(byte_done),
        .byte_addr(byte_addr), .byte_data(byte_data)
    );

    // bytes are taken only while idle or inside the load window
    assign accept = byte_done & res_n &
                    ((state_q == ST_IDLE) | (state_q == ST_LOAD));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CNT_W'(1);
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (accept) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (!res_n) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (accept) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_W'(LOAD_WIN - 1)) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!res_n) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_W'(START_DLY - 1)) begin
                    state_d = ST_PROG;
                    cnt_d   = '0;
                end
            end
            ST_PROG: begin
                if (!res_n || cnt_q == CNT_W'(PROG_CYC - 1)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            page_q  <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept && state_q == ST_IDLE) page_q <= byte_addr[ADDR_W-1:PAGE_BITS];
            if (accept) last_q <= byte_data;
        end
    end

    assign lat_clr = (state_q != ST_IDLE) && (state_d == ST_IDLE);

    eps_page_latch #(.PAGE_BITS(PAGE_BITS)) lat_i (
        .clk(clk), .rst_n(rst_n), .clr(lat_clr), .we(accept),
        .wr_idx(byte_addr[PAGE_BITS-1:0]), .wr_data(byte_data),
        .rd_idx(cnt_q[PAGE_BITS-1:0]), .rd_data(lat_rd_data),
        .rd_valid(lat_rd_valid)
    );

    // one latch entry per clock during the first PAGE_BYTES clocks of programming
    assign arr_we = (state_q == ST_PROG) && res_n &&
                    (cnt_q < CNT_W'(PAGE_BYTES)) && lat_rd_valid;

    eps_cell_array #(.ADDR_W(ADDR_W)) arr_i (
        .clk(clk), .we(arr_we),
        .waddr({page_q, cnt_q[PAGE_BITS-1:0]}), .wdata(lat_rd_data),
        .raddr(addr), .rdata(arr_rdata)
    );

    always_comb begin
        rb_low  = (state_q == ST_PROG);
        dout_en = ~ce_n & ~oe_n & we_n;
        dout    = rb_low ? {~last_q[7], last_q[6:0]} : arr_rdata;
    end

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cnt_q == CNT_W'(START_DLY - 1) && res_n) |=> rb_low);

    // R5
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_low && cnt_q == CNT_W'(PROG_CYC - 1)) |=> !rb_low);

    // R9
    res_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_n |=> !rb_low);

    // R11
    prog_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_low && $past(rb_low)) |-> $stable(last_q));

    // R6
    arr_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> rb_low);
endmodule

// File: tb/eeprom_page_seq_tb_top.sv
module eeprom_page_seq_tb_top;
    localparam int ADDR_W    = 10;
    localparam int LOAD_WIN  = 20;
    localparam int START_DLY = 60;
    localparam int PROG_CYC  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, res_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic dout_en, rb_low;

    always #10 clk = ~clk;

    eeprom_page_seq #(
        .ADDR_W(ADDR_W), .PAGE_BITS(7), .LOAD_WIN(LOAD_WIN),
        .START_DLY(START_DLY), .PROG_CYC(PROG_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .res_n(res_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .rb_low(rb_low)
    );

    typedef struct {
        logic [7:0] exp;
        int         kind;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: pops expected items and compares at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = (it.kind == 0) ? dout : {7'd0, (it.kind == 1) ? rb_low : dout_en};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input logic [7:0] e, input int k, input string t);
        item_t it;
        it.exp = e; it.kind = k; it.tag = t;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_busy(input bit e, input string t);
        @(negedge clk);
        #2 push({7'd0, e}, 1, t);
        @(negedge clk);
        #4;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        #2 push(e, 0, t);
        push(8'd1, 2, {t, " dout_en"});
        @(negedge clk);
        @(negedge clk);
        #4 ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // chip-select first, write strobe falls last
    task automatic wr_byte(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; din = d; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic wait_done();
        int n = 0;
        @(negedge clk);
        while (rb_low && n < PROG_CYC + 20) begin
            @(negedge clk);
            n++;
        end
        idle(2);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk_busy(1'b0, "R1 busy after reset");

        // R5 R7 R8: two-byte page, then polling and readback
        wr_byte(10'h005, 8'h3C);
        wr_byte(10'h021, 8'h44);
        idle(START_DLY - 8);
        chk_busy(1'b0, "R5 not busy before start delay");
        idle(8);
        chk_busy(1'b1, "R5 busy after start delay");
        rd(10'h005, 8'hC4, "R7 poll inverts bit7 of last byte");
        wait_done();
        chk_busy(1'b0, "R5 busy released after program");
        rd(10'h005, 8'h3C, "R8 stored byte 005");
        rd(10'h021, 8'h44, "R8 stored byte 021");

        // R3 R6: prior byte in page 2, then page with mixed upper bits
        wr_byte(10'h10A, 8'h77);
        idle(START_DLY + 4);
        rd(10'h10A, 8'hF7, "R7 poll single byte");
        wait_done();
        wr_byte(10'h100, 8'hA1);
        wr_byte(10'h101, 8'hB2);
        wr_byte(10'h17F, 8'hC3);
        wr_byte(10'h305, 8'h5A);
        idle(START_DLY + 4);
        rd(10'h000, 8'hDA, "R7 poll last byte of page");
        wait_done();
        rd(10'h100, 8'hA1, "R3 offset 0");
        rd(10'h101, 8'hB2, "R3 offset 1");
        rd(10'h17F, 8'hC3, "R3 offset 127");
        rd(10'h105, 8'h5A, "R3 upper bits from first byte");
        rd(10'h10A, 8'h77, "R6 unloaded entry keeps old value");

        // R2: write-strobe-first order, address and data changed while active
        @(negedge clk); addr = 10'h0FF; din = 8'h00; we_n = 1'b0;
        @(negedge clk); addr = 10'h020; ce_n = 1'b0;
        @(negedge clk); addr = 10'h021; din = 8'h11;
        @(negedge clk); din = 8'h99;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b1;
        wr_byte(10'h031, 8'h66);
        idle(START_DLY + 4);
        wait_done();
        rd(10'h020, 8'h99, "R2 address at later fall, data at first rise");
        rd(10'h021, 8'h44, "R2 address changed mid-write not used");
        rd(10'h031, 8'h66, "R2 normal byte in same page");

        // R4: byte after the window lapsed is dropped
        wr_byte(10'h030, 8'h12);
        idle(LOAD_WIN + 10);
        wr_byte(10'h031, 8'h34);
        idle(START_DLY);
        wait_done();
        rd(10'h030, 8'h12, "R4 in-window byte written");
        rd(10'h031, 8'h66, "R4 late byte ignored");

        // R10: strobe with oe_n low
        @(negedge clk); addr = 10'h030; din = 8'hFF; oe_n = 1'b0; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        idle(START_DLY + 4);
        chk_busy(1'b0, "R10 no program after oe_n low strobe");
        rd(10'h030, 8'h12, "R10 array unchanged");

        // R9: writes with res_n low, then page discarded by res_n drop
        res_n = 1'b0;
        wr_byte(10'h030, 8'hEE);
        idle(START_DLY + 4);
        chk_busy(1'b0, "R9 no program while res_n low");
        @(negedge clk); res_n = 1'b1;
        wr_byte(10'h030, 8'hDD);
        idle(5);
        @(negedge clk); res_n = 1'b0;
        idle(3);
        @(negedge clk); res_n = 1'b1;
        idle(START_DLY + 4);
        chk_busy(1'b0, "R9 discarded page not programmed");
        rd(10'h030, 8'h12, "R9 array unchanged");

        // R11: strobes while busy
        wr_byte(10'h040, 8'h01);
        idle(START_DLY + 4);
        wr_byte(10'h030, 8'h55);
        rd(10'h000, 8'h81, "R11 poll keeps last byte after busy strobe");
        wait_done();
        idle(START_DLY + 4);
        chk_busy(1'b0, "R11 no second program");
        rd(10'h030, 8'h12, "R11 busy strobe not written");
        rd(10'h040, 8'h01, "R11 page byte written");

        idle(3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule